// File: doc/BRIEF.md
# I2C Register-File Slave

This block is a bus slave for a two-wire serial bus. It gives a master read and write access to a small array of volatile byte registers. The clock and data lines are brought into the system clock domain through a short synchroniser chain. On those copies the block detects start and stop conditions, shifts bytes in and out, and answers in the acknowledge slot. It drives the data line only low, through an open-drain enable.

A transaction begins with an address byte that carries a fixed 7-bit device identifier and a direction bit. A write then supplies a register index followed by any number of data bytes. A read returns bytes from the current register pointer. The pointer advances by one after every data byte in either direction, wraps at the end of the array, and keeps its value from one transaction to the next. A master can therefore set the pointer with a write that carries no data and then read from that position.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, the pointer is 0 and every register reads 0. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Both are detected on the synchronised lines, and either one restarts the byte machine.
- R2: The first byte after START is compared MSB first. Bits 7..1 must equal 7'b1000100 and bit 0 gives the direction (1 = read, 0 = write). On a match the slave holds sda_oe_o at 1 while SCL is high on the ninth clock.
- R3: On an identifier mismatch the slave does not acknowledge. It keeps sda_oe_o at 0 until the next START or STOP, and no register or pointer changes.
- R4: In a write, the slave acknowledges the byte after the address byte as a register index. Its bits 2..0 load the pointer and bits 7..3 are ignored.
- R5: In a write, the slave acknowledges each later byte, stores it in the register at the pointer, and then adds one to the pointer.
- R6: The pointer wraps from register 7 to register 0, in both writes and reads.
- R7: The pointer keeps its value across STOP and across a repeated START.
- R8: In a read, the slave sends the register at the pointer MSB first. sda_oe_o is 1 for a 0 bit and 0 for a 1 bit, it is 0 on the ninth clock, and the pointer advances by one after each byte.
- R9: If the master acknowledges (SDA low on the ninth clock), the next byte follows. If it does not, sda_oe_o stays 0 until the next START or STOP.
- R10: sda_oe_o changes only while SCL is low.
- R11: A STOP that ends a transaction in which at least one data byte was stored starts a 4-clock hold. During the hold sda_oe_o is 0 and a START is ignored, and the transaction that START opens is not answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Drive-low enable for the data line |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms START or STOP. They also assume that each SCL phase lasts well beyond the synchroniser delay, so the edge order seen on the synchronised copies matches the wire. The stimulus holds each SCL phase for several clocks and changes SDA half a phase after SCL falls. The one deliberately tight sequence places a START two clocks after a STOP, to land inside the post-write hold.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
  } rf_state_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // bit 1 = scl, bit 0 = sda
  logic [1:0] sync_q [STAGES];
  logic [1:0] prev_q, cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      sync_q[0] <= {scl_i, sda_i};
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur        = sync_q[STAGES-1];
  assign sda_o      = cur[0];
  assign scl_rise_o = cur[1] & ~prev_q[1];
  assign scl_fall_o = ~cur[1] & prev_q[1];
  assign start_o    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
  assign stop_o     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int AW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_ld_i,
  input  logic [AW-1:0] ptr_val_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [NREG];
  logic [AW-1:0] ptr_q, ptr_nxt;

  generate
    if ((1 << AW) == NREG) begin : g_pow2
      assign ptr_nxt = ptr_q + AW'(1);
    end else begin : g_cmp
      assign ptr_nxt = (ptr_q == AW'(NREG-1)) ? '0 : ptr_q + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      if (ptr_ld_i)   ptr_q <= ptr_val_i;
      else if (inc_i) ptr_q <= ptr_nxt;
      if (wr_en_i) mem_q[ptr_q] <= wdata_i;
    end
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = mem_q[ptr_q];
endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ID  = 7'h44,
  parameter int         DW      = 8,
  parameter int         AW      = 3,
  parameter int         WR_HOLD = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rdata_i,
  output logic          sda_oe_o,
  output logic          ptr_ld_o,
  output logic [AW-1:0] ptr_val_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wdata_o,
  output logic          inc_o,
  output rf_state_e     state_o,
  output logic          busy_o
);
  localparam int CW = $clog2(DW + 1);
  localparam int BW = $clog2(WR_HOLD + 1);

  rf_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sr_q, tx_q;
  logic          oe_q, rw_q, nack_q, wr_seen_q;
  logic [BW-1:0] busy_q;
  logic          byte_end, live;

  assign byte_end  = scl_fall_i && (cnt_q == CW'(DW));
  assign live      = (busy_q == '0) && !start_i && !stop_i;
  assign wr_en_o   = live && (st_q == ST_WR) && byte_end;
  assign ptr_ld_o  = live && (st_q == ST_REG) && byte_end;
  assign inc_o     = wr_en_o || (live && (st_q == ST_RD) && byte_end);
  assign ptr_val_o = sr_q[AW-1:0];
  assign wdata_o   = sr_q;
  assign sda_oe_o  = oe_q;
  assign state_o   = st_q;
  assign busy_o    = (busy_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sr_q <= '0; tx_q <= '0;
      oe_q <= 1'b0; rw_q <= 1'b0; nack_q <= 1'b0; wr_seen_q <= 1'b0;
      busy_q <= '0;
    end else if (busy_q != '0) begin
      busy_q <= busy_q - BW'(1);
      st_q   <= ST_IDLE;
      oe_q   <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE; oe_q <= 1'b0; wr_seen_q <= 1'b0;
      if (wr_seen_q) busy_q <= BW'(WR_HOLD);
    end else if (start_i) begin
      st_q <= ST_DEV; cnt_q <= '0; oe_q <= 1'b0; wr_seen_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise_i) begin
            sr_q  <= {sr_q[DW-2:0], sda_i};
            cnt_q <= cnt_q + CW'(1);
          end else if (byte_end) begin
            if (st_q == ST_DEV) begin
              if (sr_q[DW-1:1] == DEV_ID) begin
                rw_q <= sr_q[0]; oe_q <= 1'b1; st_q <= ST_DEV_ACK;
              end else begin
                st_q <= ST_WAIT;
              end
            end else if (st_q == ST_REG) begin
              oe_q <= 1'b1; st_q <= ST_REG_ACK;
            end else begin
              oe_q <= 1'b1; st_q <= ST_WR_ACK; wr_seen_q <= 1'b1;
            end
          end
        end
        ST_DEV_ACK: if (scl_fall_i) begin
          cnt_q <= '0;
          if (rw_q) begin
            st_q <= ST_RD; tx_q <= rdata_i; oe_q <= ~rdata_i[DW-1];
          end else begin
            st_q <= ST_REG; oe_q <= 1'b0;
          end
        end
        ST_REG_ACK, ST_WR_ACK: if (scl_fall_i) begin
          cnt_q <= '0; oe_q <= 1'b0; st_q <= ST_WR;
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + CW'(1);
          end else if (byte_end) begin
            oe_q <= 1'b0; st_q <= ST_RD_ACK;
          end else if (scl_fall_i) begin
            oe_q <= ~tx_q[DW-2];
            tx_q <= {tx_q[DW-2:0], 1'b0};
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            nack_q <= sda_i;
          end else if (scl_fall_i) begin
            cnt_q <= '0;
            if (nack_q) begin
              st_q <= ST_WAIT; oe_q <= 1'b0;
            end else begin
              st_q <= ST_RD; tx_q <= rdata_i; oe_q <= ~rdata_i[DW-1];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'h44,
  parameter int         NREG        = 8,
  parameter int         DW          = 8,
  parameter int         WR_HOLD     = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

  logic          sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic          ptr_ld_w, wr_en_w, inc_w, busy_w;
  logic [AW-1:0] ptr_val_w, ptr_w;
  logic [DW-1:0] wdata_w, rdata_w;
  rf_state_e     state_w;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2c_rf_fsm #(.DEV_ID(DEV_ID), .DW(DW), .AW(AW), .WR_HOLD(WR_HOLD)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise_w), .scl_fall_i(scl_fall_w),
    .start_i(start_w), .stop_i(stop_w), .rdata_i(rdata_w), .sda_oe_o,
    .ptr_ld_o(ptr_ld_w), .ptr_val_o(ptr_val_w), .wr_en_o(wr_en_w), .wdata_o(wdata_w),
    .inc_o(inc_w), .state_o(state_w), .busy_o(busy_w)
  );

  i2c_rf_regs #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .ptr_ld_i(ptr_ld_w), .ptr_val_i(ptr_val_w), .wr_en_i(wr_en_w),
    .wdata_i(wdata_w), .inc_i(inc_w), .ptr_o(ptr_w), .rdata_o(rdata_w)
  );
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk
  import i2c_rf_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          wr_en_i,
  input logic          inc_i,
  input logic [AW-1:0] ptr_i,
  input rf_state_e     st_i,
  input logic          busy_i
);
  logic wrote_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             wrote_q <= 1'b0;
    else if ((start_i || stop_i) && !busy_i) wrote_q <= 1'b0;
    else if (wr_en_i)                        wrote_q <= 1'b1;
  end

  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_i);
  // R1
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> st_i == ST_DEV && !sda_oe_i);
  // R3
  wait_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_WAIT |-> !sda_oe_i);
  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && ptr_i != AW'(NREG-1) |=> ptr_i == AW'($past(ptr_i) + AW'(1)));
  // R6
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && ptr_i == AW'(NREG-1) |=> ptr_i == '0);
  // R11
  hold_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && wrote_q && !busy_i |=> busy_i);
  // R11
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);
  // R11
  hold_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_i |=> st_i == ST_IDLE);
endmodule

bind i2c_regfile_slave i2c_rf_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_i(sda_oe_o),
  .start_i(start_w), .stop_i(stop_w), .wr_en_i(wr_en_w), .inc_i(inc_w),
  .ptr_i(ptr_w), .st_i(state_w), .busy_i(busy_w)
);

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  bus_sda = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] model_regs [8];
  int model_ptr = 0;

  always #4 clk = ~clk;

  i2c_regfile_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(bus_sda), .sda_oe_o(sda_oe)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk1(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk8(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", tag, got, exp, $time);
    end
  endtask

  // one SCL period; oe is compared in mid-high and late-high
  task automatic clk_bit(input logic b, input logic exp_oe, input string tag, output logic seen);
    sda_m = b;
    wait_n(8);
    scl_m = 1'b1;
    wait_n(4);
    chk1(sda_oe, exp_oe, tag);
    seen = bus_sda;
    wait_n(3);
    chk1(sda_oe, exp_oe, "R10");
    scl_m = 1'b0;
    wait_n(4);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wait_n(4);
    scl_m = 1'b1; wait_n(8);
    sda_m = 1'b0; wait_n(8);
    scl_m = 1'b0; wait_n(4);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wait_n(8);
    scl_m = 1'b1; wait_n(8);
    sda_m = 1'b1; wait_n(8);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], 1'b0, tag, s);
    clk_bit(1'b1, exp_ack, tag, s);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~exp[i], tag, s);
      got[i] = s;
    end
    chk8(got, exp, tag);
    clk_bit(~mack, 1'b0, "R9", s);
  endtask

  // write n bytes from index a; n = 0 only sets the pointer
  task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] seed, input string tag);
    logic [7:0] d;
    start_c();
    send_byte(8'h88, 1'b1, "R2");
    send_byte(a, 1'b1, "R4");
    model_ptr = int'(a[2:0]);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 29);
      send_byte(d, 1'b1, tag);
      model_regs[model_ptr] = d;
      model_ptr = (model_ptr + 1) % 8;
    end
    stop_c();
    wait_n(20);
  endtask

  task automatic do_read(input int n, input string tag);
    start_c();
    send_byte(8'h89, 1'b1, "R2");
    for (int k = 0; k < n; k++) begin
      recv_byte(model_regs[model_ptr], (k != n - 1), tag);
      model_ptr = (model_ptr + 1) % 8;
    end
    stop_c();
    wait_n(20);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired got=running exp=finished");
    finish_run();
  end

  initial begin
    logic s;
    for (int i = 0; i < 8; i++) model_regs[i] = 8'h00;
    wait_n(10);
    chk1(sda_oe, 1'b0, "R1 reset");
    rst_ni = 1'b1;
    wait_n(10);
    chk1(sda_oe, 1'b0, "R1 idle");
    do_read(2, "R1 reset contents");

    // R5 R6 fill all eight, pointer wraps to 0
    do_write(8'h00, 8, 8'h11, "R5");
    // R7 pointer retained after STOP
    do_read(3, "R7");
    // R4 upper index bits ignored: F9 -> 1
    do_write(8'hF9, 0, 8'h00, "R4");
    do_read(2, "R4 R8");
    // R6 burst write across the wrap, then read across it
    do_write(8'h06, 4, 8'hC3, "R6 write");
    do_write(8'h06, 0, 8'h00, "R6");
    do_read(4, "R6 read");

    // R3 identifier mismatch: nothing answered, nothing stored
    start_c();
    send_byte(8'h8A, 1'b0, "R3");
    send_byte(8'h02, 1'b0, "R3");
    send_byte(8'hFF, 1'b0, "R3");
    stop_c();
    wait_n(20);
    do_read(1, "R3 unchanged");

    // R9 NACK: slave stays released afterwards
    start_c();
    send_byte(8'h89, 1'b1, "R2");
    recv_byte(model_regs[model_ptr], 1'b0, "R8");
    model_ptr = (model_ptr + 1) % 8;
    for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, "R9 after nack", s);
    stop_c();
    wait_n(20);

    // R7 repeated START keeps the pointer set in the same transfer
    start_c();
    send_byte(8'h88, 1'b1, "R2");
    send_byte(8'h05, 1'b1, "R4");
    model_ptr = 5;
    start_c();
    send_byte(8'h89, 1'b1, "R7");
    recv_byte(model_regs[model_ptr], 1'b1, "R7");
    model_ptr = (model_ptr + 1) % 8;
    recv_byte(model_regs[model_ptr], 1'b0, "R7");
    model_ptr = (model_ptr + 1) % 8;
    stop_c();
    wait_n(20);

    // R11 START two clocks after a write-ending STOP is ignored
    start_c();
    send_byte(8'h88, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h3C, 1'b1, "R5");
    model_regs[0] = 8'h3C;
    model_ptr = 1;
    sda_m = 1'b0; wait_n(8);
    scl_m = 1'b1; wait_n(8);
    sda_m = 1'b1; wait_n(2);
    sda_m = 1'b0; wait_n(8);
    scl_m = 1'b0; wait_n(4);
    send_byte(8'h89, 1'b0, "R11");
    clk_bit(1'b1, 1'b0, "R11", s);
    stop_c();
    wait_n(20);
    do_read(1, "R11 after hold");
    do_write(8'h00, 0, 8'h00, "R4");
    do_read(2, "R8 final");

    finish_run();
  end
endmodule